// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block receives clocked-synchronous serial data and produces the serial clock itself. A baud-rate tick from elsewhere in the chip advances a two-bit phase counter. One full count of that counter, four ticks, is one period of the serial clock output. The data input is captured on one phase of the count. On the following phase, the captured bit is moved into a shift register.

Software or a controller arms the receiver with a one-cycle enable-set strobe. Reception starts at the next shift phase. After one word has been received, the word is placed in a receive buffer and a one-cycle completion pulse is raised. The enable then clears itself, so each frame needs a fresh enable-set.

An overrun flag records that a word was replaced before it had been read. The data input passes through a parameterised synchroniser before it is captured. For that reason the baud tick must be spaced at least SYNC_STAGES + 1 system clocks apart.

Top module: `srx_master_rx`

## Requirements
- R1: After reset, sclk_o is 1, rx_en is 0, rx_done is 0, overrun is 0 and rx_data is all zeros.
- R2: While a frame is in progress, sclk_o has a period of four baud ticks. It is low for two ticks (phases 0 and 1) and high for two ticks (phases 2 and 3). It changes only in the cycle after a baud tick.
- R3: While no frame is in progress, sclk_o stays at 1. No clock pulses appear while rx_en is 0.
- R4: A one-cycle en_set sets rx_en. The frame starts at the next baud tick that moves the phase to 3. Every frame then produces exactly DATA_W falling edges on sclk_o.
- R5: sdi is captured as sclk_o rises (the phase moves to 2). The captured bit enters the shift register on the next tick (the phase moves to 3). Bits arrive LSB first, one per falling edge. rx_data changes only when a new word is loaded.
- R6: rx_done is high for exactly one clock cycle per frame. It is high in the same cycle in which rx_data first shows the new word.
- R7: rx_en clears itself in the cycle the word is loaded. No further sclk_o pulses occur until en_set is given again.
- R8: If a word is loaded while the previous word is still unread and rd_stb is low in that cycle, overrun becomes 1. The new word replaces the old one.
- R9: rd_stb clears overrun and marks the buffer as read. If rd_stb coincides with a load, no overrun is raised, and the new word counts as unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle baud-rate tick that advances the phase counter |
| en_set | input | 1 | One-cycle strobe that arms reception of one frame |
| sdi | input | 1 | Serial data input |
| rd_stb | input | 1 | Buffer read strobe |
| sclk_o | output | 1 | Generated serial clock, idles high |
| rx_en | output | 1 | Receive enable state, self-clearing |
| rx_data | output | DATA_W | Receive buffer contents |
| rx_done | output | 1 | One-cycle receive-complete pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A phase counter that is off by one shows up within one frame. It either moves the capture point into the low half of sclk_o, which scrambles the received word, or it changes the clock period that the bench measures between falling edges. An off-by-one bit counter changes the number of falling edges per frame and shifts the word by one bit. Both are visible at the next rx_done. A stuck enable or an active state that fails to clear leaves sclk_o toggling after rx_done, which shows within a few ticks. A wrong unread marker shows as an overrun that is missing or spurious on the frame that follows.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef logic [1:0] phase_t;
    // phase reached on the tick that captures the data input
    localparam phase_t PH_CAPTURE = 2'd2;
    // phase reached on the tick that shifts the captured bit
    localparam phase_t PH_SHIFT   = 2'd3;
endpackage

// File: rtl/srx_phase_gen.sv
module srx_phase_gen
    import srx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    output phase_t phase_next,
    output logic   capture_evt,
    output logic   shift_evt
);
    typedef struct packed {
        phase_t ph;
    } pg_state_t;

    pg_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        capture_evt = 1'b0;
        shift_evt   = 1'b0;
        if (tick) begin
            st_d.ph     = st_q.ph + 2'd1;
            capture_evt = (st_d.ph == PH_CAPTURE);
            shift_evt   = (st_d.ph == PH_SHIFT);
        end
        phase_next = st_d.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              capture_evt,
    input  logic              shift_evt,
    input  logic              active,
    output logic [DATA_W-1:0] word_next,
    output logic              last_bit
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic sdi_s;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign sdi_s = sdi;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= sdi;
                    for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
                end
            end
            assign sdi_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    typedef struct packed {
        logic              hold;
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        word_next = {st_q.hold, st_q.sr[DATA_W-1:1]};
        last_bit  = shift_evt && active && (st_q.cnt == LAST_IDX);
        if (capture_evt) st_d.hold = sdi_s;
        if (!active) begin
            st_d.cnt = '0;
        end else if (shift_evt) begin
            st_d.sr  = word_next;
            st_d.cnt = last_bit ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] data,
    output logic              done,
    output logic              ovr
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              done;
        logic              unread;
        logic              ovr;
    } bf_state_t;

    bf_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = load;
        if (rd_stb) begin
            st_d.unread = 1'b0;
            st_d.ovr    = 1'b0;
        end
        if (load) begin
            st_d.data   = word;
            st_d.unread = 1'b1;
            if (st_q.unread && !rd_stb) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign done = st_q.done;
    assign ovr  = st_q.ovr;
endmodule

// File: rtl/srx_master_rx.sv
module srx_master_rx
    import srx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              en_set,
    input  logic              sdi,
    input  logic              rd_stb,
    output logic              sclk_o,
    output logic              rx_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              overrun
);
    phase_t            phase_next;
    logic              capture_evt;
    logic              shift_evt;
    logic              last_bit;
    logic [DATA_W-1:0] word_next;

    typedef struct packed {
        logic en;
        logic active;
        logic sclk;
    } ct_state_t;

    ct_state_t st_d, st_q;

    srx_phase_gen u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .phase_next  (phase_next),
        .capture_evt (capture_evt),
        .shift_evt   (shift_evt)
    );

    srx_shifter #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sdi         (sdi),
        .capture_evt (capture_evt),
        .shift_evt   (shift_evt),
        .active      (st_q.active),
        .word_next   (word_next),
        .last_bit    (last_bit)
    );

    srx_rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (last_bit),
        .word   (word_next),
        .rd_stb (rd_stb),
        .data   (rx_data),
        .done   (rx_done),
        .ovr    (overrun)
    );

    always_comb begin
        st_d = st_q;
        // frame completion wins over a simultaneous enable-set
        if (last_bit)    st_d.en = 1'b0;
        else if (en_set) st_d.en = 1'b1;

        if (last_bit)                                  st_d.active = 1'b0;
        else if (shift_evt && st_q.en && !st_q.active) st_d.active = 1'b1;

        // low on phases 0 and 1, high on 2 and 3, high when idle
        st_d.sclk = st_d.active ? phase_next[1] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b0, active: 1'b0, sclk: 1'b1};
        else        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;
    assign rx_en  = st_q.en;
endmodule

// File: rtl/srx_master_rx_chk.sv
module srx_master_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              rd_stb,
    input logic              sclk_o,
    input logic              rx_en,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_done,
    input logic              overrun
);
    p_sclk_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> $past(baud_tick));

    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> sclk_o);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_data));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    p_done_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (!rx_en && $past(rx_en)));

    p_ovr_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> rx_done);

    p_read_clears_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb) |-> !overrun);
endmodule

bind srx_master_rx srx_master_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .rd_stb    (rd_stb),
    .sclk_o    (sclk_o),
    .rx_en     (rx_en),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .overrun   (overrun)
);

// File: tb/srx_master_rx_bench.sv
module srx_master_rx_bench;
    localparam int DW       = 8;
    localparam int TICK_DIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic en_set = 1'b0;
    logic sdi = 1'b0;
    logic rd_stb = 1'b0;
    logic sclk_o;
    logic rx_en;
    logic [DW-1:0] rx_data;
    logic rx_done;
    logic overrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fall_cnt = 0;
    int last_fall = 0;
    int prev_fall = 0;
    int last_rise = 0;
    int done_seen = 0;
    logic [DW-1:0] exp_q[$];

    srx_master_rx #(.DATA_W(DW), .SYNC_STAGES(2)) u_srx_master_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en_set(en_set),
        .sdi(sdi), .rd_stb(rd_stb), .sclk_o(sclk_o), .rx_en(rx_en),
        .rx_data(rx_data), .rx_done(rx_done), .overrun(overrun)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // baud tick: one cycle high every TICK_DIV cycles
    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            baud_tick = (t == 0);
            t = (t + 1) % TICK_DIV;
        end
    end

    // edge monitor on the generated clock
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev && !sclk_o) begin
                    prev_fall = last_fall;
                    last_fall = cyc;
                    fall_cnt++;
                end
                if (!prev && sclk_o) last_rise = cyc;
            end
            prev = sclk_o;
        end
    end

    // scoreboard monitor
    initial begin
        logic prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (prev_done) chk(!rx_done, "R6 done width", rx_done, 0);
            if (rx_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R5 received word", rx_data, e);
                end
                chk(!rx_en, "R7 enable cleared at done", rx_en, 0);
                done_seen++;
            end
            prev_done = rx_done;
        end
    end

    task automatic send(input logic [DW-1:0] w, input bit hold_rd);
        int f0 = fall_cnt;
        int d0 = done_seen;
        exp_q.push_back(w);
        @(negedge clk) en_set = 1'b1;
        @(negedge clk) en_set = 1'b0;
        chk(rx_en, "R4 en_set arms", rx_en, 1);
        for (int i = 0; i < DW; i++) begin
            wait (fall_cnt == f0 + i + 1);
            sdi = w[i];
            if (i == DW - 1 && hold_rd) rd_stb = 1'b1;
        end
        wait (done_seen == d0 + 1);
        rd_stb = 1'b0;
        repeat (30) @(negedge clk);
        chk(fall_cnt - f0 == DW, "R4 falling edges per frame", fall_cnt - f0, DW);
        chk(sclk_o, "R7 clock stopped after frame", sclk_o, 1);
    endtask

    task automatic read_buf();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(sclk_o == 1'b1, "R1 sclk reset", sclk_o, 1);
        chk(rx_en == 1'b0, "R1 enable reset", rx_en, 0);
        chk(rx_done == 1'b0 && overrun == 1'b0, "R1 flags reset", {rx_done, overrun}, 0);
        chk(rx_data == '0, "R1 data reset", rx_data, 0);
        rst_n = 1'b1;

        // R3: ticks run but nothing armed
        repeat (60) @(negedge clk);
        chk(fall_cnt == 0, "R3 no clock while idle", fall_cnt, 0);
        chk(sclk_o == 1'b1, "R3 idle high", sclk_o, 1);
        chk(done_seen == 0, "R3 no frame while idle", done_seen, 0);

        send(8'hA5, 1'b0);
        chk(last_fall - prev_fall == 4 * TICK_DIV, "R2 clock period", last_fall - prev_fall, 4 * TICK_DIV);
        chk(last_rise - last_fall == 2 * TICK_DIV, "R2 low width", last_rise - last_fall, 2 * TICK_DIV);
        chk(!overrun, "R8 no overrun on first word", overrun, 0);

        read_buf();
        send(8'h3C, 1'b0);
        chk(!overrun, "R8 no overrun after read", overrun, 0);

        // read coincides with the load of the next word
        send(8'h81, 1'b1);
        chk(!overrun, "R9 read at load avoids overrun", overrun, 0);

        // the word loaded under the read still counts as unread
        send(8'h5A, 1'b0);
        chk(overrun, "R8 overrun on unread word", overrun, 1);
        chk(rx_data == 8'h5A, "R8 word overwritten", rx_data, 8'h5A);

        read_buf();
        chk(!overrun, "R9 read clears overrun", overrun, 0);
        chk(rx_data == 8'h5A, "R5 data held after read", rx_data, 8'h5A);

        send(8'hFF, 1'b0);
        chk(!overrun, "R9 buffer marked read", overrun, 0);
        send(8'h00, 1'b0);
        chk(overrun, "R8 overrun again", overrun, 1);
        chk(exp_q.size() == 0, "R6 one done per frame", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule